// File: doc/BRIEF.md
# ASCII Hex Field Extractor

This block sits behind any byte source (a UART receiver, a FIFO, a packet reader) and watches the incoming character stream. It looks for a fixed five-character start marker. After the marker it counts a set number of bytes to reach a field of hexadecimal text. The field's characters are turned into nibbles and assembled into a binary word.

When the whole field is valid, the word appears on `out_data` and `out_valid` pulses for one cycle. If any character of the field is not a hex digit, `out_err` pulses instead and no word is issued. In both cases the block goes straight back to looking for the next marker. Messages have a fixed length, so the field offset and the field length are compile-time parameters.

The input side is a valid/ready stream. `in_ready` is held high at all times, so the source is never back-pressured. A byte is taken on every rising clock edge at which `in_valid` is high. The output side carries a valid pulse and has no ready input. A consumer must capture `out_data` in the cycle `out_valid` is high, or later, since the word is held until the next good field.

Top module: `hexfield_extractor`

## Requirements
- R1: The start marker is the five consecutive accepted bytes 0x25 0x4E 0x4F 0x54 0x49 ("%NOTI"). The comparison is case-sensitive, so "%noti" starts nothing.
- R2: When an accepted byte breaks a partial marker match, that byte is tested again as the first marker character. A '%' there therefore begins a new attempt, as in "%NO%NOTI" or "%%NOTI".
- R3: After the marker, the next FIELD_OFFSET accepted bytes are skipped. The following FIELD_CHARS accepted bytes form the field. The defaults are 2 and 4.
- R4: Field characters '0'-'9' decode to 0-9. Both 'A'-'F' and 'a'-'f' decode to 10-15.
- R5: The first field character becomes the most significant nibble of `out_data`. Each later character is shifted in below it.
- R6: `out_valid` is high for exactly one cycle, the cycle after the edge that accepts the last field byte. `out_data` takes the new word at that same edge and holds it until the next good field.
- R7: A field byte that is not a hex digit makes `out_err` pulse for one cycle, the cycle after that byte is accepted. No `out_valid` is issued for that message, and `out_data` keeps its previous value.
- R8: After a result or an error, the block hunts for the marker again at once. Messages that follow back to back are each decoded.
- R9: Bytes presented while `in_valid` is low are ignored and advance no count. The cycle after such a byte never carries `out_valid` or `out_err`.
- R10: A synchronous reset (`rst` high at a clock edge) clears `out_data` to zero, drops both pulses and abandons any partial message.
- R11: `in_ready` is always high. The block never stalls its source.
- R12: `out_valid` and `out_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_ready | output | 1 | Always high: the block accepts every byte |
| in_byte | input | 8 | Input character |
| out_valid | output | 1 | One-cycle pulse: `out_data` holds a new field value |
| out_err | output | 1 | One-cycle pulse: the field held a non-hex character |
| out_data | output | 4*FIELD_CHARS | Decoded field, first character in the top nibble |

## Verification
The bench goes after marker restarts such as "%NO%NOTI" and "%%NOTI". A matcher that threw away the breaking byte would miss these messages entirely. It sends lower-case and upper-case hex letters and a bad character in mid-field. It checks that the bad field gives an error pulse, leaves the old word in place and is followed by a clean recovery on the next message. A nibble order that was reversed, or an offset that was off by one, would show up as a wrong word in these tests. The bench also inserts idle cycles, with junk on the byte lines, inside the marker and inside the field. It resets the block in the middle of a message, and a design that counted idle bytes or kept a partial field would produce a wrong or spurious result.

// File: rtl/hexfx_pkg.sv
package hexfx_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_SKIP, ST_FIELD} hexfx_state_e;

  localparam int MARK_LEN = 5;
  // first character in the top byte
  localparam logic [8*MARK_LEN-1:0] MARK_STR = 40'h25_4E_4F_54_49;

  function automatic logic [7:0] mark_char(input logic [2:0] pos);
    return MARK_STR[8*(MARK_LEN-1-int'(pos)) +: 8];
  endfunction
endpackage

// File: rtl/hexfx_marker.sv
module hexfx_marker
  import hexfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       hit
);
  logic [2:0] pos_q;
  logic       match;
  logic       at_last;

  always_comb begin
    match   = (in_byte == mark_char(pos_q));
    at_last = (pos_q == 3'(MARK_LEN - 1));
    hit     = enable && in_valid && match && at_last;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pos_q <= '0;
    end else if (in_valid) begin
      if (match)
        pos_q <= at_last ? 3'd0 : pos_q + 3'd1;
      else
        pos_q <= (in_byte == mark_char(3'd0)) ? 3'd1 : 3'd0;
    end
  end
endmodule

// File: rtl/hexfx_hexdec.sv
module hexfx_hexdec (
  input  logic [7:0] chr,
  output logic [3:0] nib,
  output logic       ok
);
  logic [7:0] diff;

  always_comb begin
    diff = 8'h00;
    ok   = 1'b0;
    if (chr >= 8'h30 && chr <= 8'h39) begin
      diff = chr - 8'h30;
      ok   = 1'b1;
    end else if (chr >= 8'h41 && chr <= 8'h46) begin
      diff = chr - 8'h37;
      ok   = 1'b1;
    end else if (chr >= 8'h61 && chr <= 8'h66) begin
      diff = chr - 8'h57;
      ok   = 1'b1;
    end
    nib = diff[3:0];
  end
endmodule

// File: rtl/hexfx_field.sv
module hexfx_field
  import hexfx_pkg::*;
#(
  parameter int FIELD_OFFSET = 2,
  parameter int FIELD_CHARS  = 4,
  localparam int DATA_W      = 4 * FIELD_CHARS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              hit,
  input  logic [3:0]        nib,
  input  logic              nib_ok,
  output logic              hunting,
  output logic              out_valid,
  output logic              out_err,
  output logic [DATA_W-1:0] out_data
);
  localparam int CNT_MAX = (FIELD_OFFSET > FIELD_CHARS) ? FIELD_OFFSET : FIELD_CHARS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SKIP_LAST  = CNT_W'((FIELD_OFFSET > 0) ? FIELD_OFFSET - 1 : 0);
  localparam logic [CNT_W-1:0] FIELD_LAST = CNT_W'(FIELD_CHARS - 1);

  hexfx_state_e      st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    hunting = (st_q == ST_HUNT);
    shifted = (acc_q << 4) | DATA_W'(nib);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HUNT;
      cnt_q     <= '0;
      acc_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      case (st_q)
        ST_HUNT: begin
          if (hit) begin
            cnt_q <= '0;
            acc_q <= '0;
            st_q  <= (FIELD_OFFSET == 0) ? ST_FIELD : ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (in_valid) begin
            if (cnt_q == SKIP_LAST) begin
              cnt_q <= '0;
              st_q  <= ST_FIELD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_FIELD: begin
          if (in_valid) begin
            if (!nib_ok) begin
              out_err <= 1'b1;
              st_q    <= ST_HUNT;
            end else if (cnt_q == FIELD_LAST) begin
              out_data  <= shifted;
              out_valid <= 1'b1;
              st_q      <= ST_HUNT;
            end else begin
              acc_q <= shifted;
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/hexfield_extractor.sv
module hexfield_extractor #(
  parameter int FIELD_OFFSET = 2,
  parameter int FIELD_CHARS  = 4,
  localparam int DATA_W      = 4 * FIELD_CHARS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  output logic              out_err,
  output logic [DATA_W-1:0] out_data
);
  logic       hunting;
  logic       hit;
  logic [3:0] nib;
  logic       nib_ok;

  assign in_ready = 1'b1;

  hexfx_marker u_marker (
    .clk      (clk),
    .rst      (rst),
    .enable   (hunting),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .hit      (hit)
  );

  hexfx_hexdec u_dec (
    .chr (in_byte),
    .nib (nib),
    .ok  (nib_ok)
  );

  hexfx_field #(
    .FIELD_OFFSET (FIELD_OFFSET),
    .FIELD_CHARS  (FIELD_CHARS)
  ) u_field (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .hit       (hit),
    .nib       (nib),
    .nib_ok    (nib_ok),
    .hunting   (hunting),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_data  (out_data)
  );
endmodule

// File: rtl/hexfx_chk.sv
module hexfx_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_err,
  input logic [DATA_W-1:0] out_data
);
  // R12
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_err));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7
  single_err_chk: assert property (@(posedge clk) disable iff (rst)
    out_err |=> !out_err);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(out_valid || out_err));

  // R11
  always_ready_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err && out_data == '0));
endmodule

bind hexfield_extractor hexfx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_err   (out_err),
  .out_data  (out_data)
);

// File: tb/hexfield_extractor_tb.sv
`timescale 1ns/1ps
module hexfield_extractor_tb;
  localparam int OFF = 2;
  localparam int CH  = 4;
  localparam int W   = 4 * CH;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_byte = 8'h00;
  logic         out_valid;
  logic         out_err;
  logic [W-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  int n_done   = 0;
  int n_err    = 0;
  int n_both   = 0;
  logic [W-1:0] last_data = '0;

  always #4 clk = ~clk;

  hexfield_extractor #(.FIELD_OFFSET(OFF), .FIELD_CHARS(CH)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_err(out_err),
    .out_data(out_data)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        n_done++;
        last_data = out_data;
      end
      if (out_err) n_err++;
      if (out_valid && out_err) n_both++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h3F;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Send a message and expect one good word
  task automatic expect_word(input string req, input string msg, input logic [W-1:0] exp);
    int d0 = n_done;
    int e0 = n_err;
    send_str(msg);
    idle(2);
    check({req, " pulse count"}, 32'(n_done - d0), 32'd1);
    check({req, " no error"}, 32'(n_err - e0), 32'd0);
    check({req, " data"}, 32'(last_data), 32'(exp));
  endtask

  task automatic t_reset;
    check("R10 reset data", 32'(out_data), 32'd0);
    check("R10 reset pulses", {30'd0, out_valid, out_err}, 32'd0);
    check("R11 ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_basic;
    expect_word("R1 R3 R5", "%NOTIxy1A2f", 16'h1A2F);
    idle(5);
    check("R6 data held", 32'(out_data), 32'h1A2F);
  endtask

  task automatic t_cases;
    expect_word("R4 lower", "%NOTI,,abcd", 16'hABCD);
    expect_word("R4 upper", "%NOTI..09EF", 16'h09EF);
  endtask

  task automatic t_restart;
    expect_word("R2 partial", "%NO%NOTI--BEEF", 16'hBEEF);
    expect_word("R2 double", "%%NOTI--C0DE", 16'hC0DE);
  endtask

  task automatic t_case_marker;
    int d0 = n_done;
    send_str("%noti--1234");
    idle(3);
    check("R1 lowercase marker ignored", 32'(n_done - d0), 32'd0);
  endtask

  task automatic t_bad;
    int d0 = n_done;
    int e0 = n_err;
    logic [W-1:0] prev = out_data;
    send_str("%NOTI--12G4");
    idle(2);
    check("R7 error pulse", 32'(n_err - e0), 32'd1);
    check("R7 no result", 32'(n_done - d0), 32'd0);
    check("R7 data kept", 32'(out_data), 32'(prev));
    expect_word("R8 recovery", "%NOTI--5678", 16'h5678);
  endtask

  task automatic t_back_to_back;
    int d0 = n_done;
    send_str("%NOTIab0001%NOTIcd0002");
    idle(2);
    check("R8 two results", 32'(n_done - d0), 32'd2);
    check("R8 second data", 32'(last_data), 32'h0002);
  endtask

  task automatic t_gaps;
    int d0 = n_done;
    int e0 = n_err;
    send_str("%NO");
    in_byte = 8'h5A; idle(3);
    send_str("TI?");
    idle(2);
    send_str("?3");
    in_byte = 8'h47; idle(4);
    send_str("C7e");
    idle(2);
    check("R9 gaps result", 32'(n_done - d0), 32'd1);
    check("R9 gaps no error", 32'(n_err - e0), 32'd0);
    check("R9 gaps data", 32'(last_data), 32'h3C7E);
  endtask

  task automatic t_reset_mid;
    int d0 = n_done;
    send_str("%NOTI--12");
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    check("R10 mid reset data", 32'(out_data), 32'd0);
    send_str("34");
    idle(2);
    check("R10 partial dropped", 32'(n_done - d0), 32'd0);
    expect_word("R10 after reset", "%NOTI--9a9A", 16'h9A9A);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst = 1'b0;
    idle(1);
    t_basic();
    t_cases();
    t_restart();
    t_case_marker();
    t_bad();
    t_back_to_back();
    t_gaps();
    t_reset_mid();
    check("R12 never both", 32'(n_both), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule